// File: doc/BRIEF.md
# Consumer Clock Source Selector Bank

This block serves a group of six on-chip clock consumers. Every consumer has its own selector. A selector picks one source from seven candidates: the auxiliary clock or one of six frequency-generator outputs. It then divides that source by a small ratio. All sources reach the block as single-cycle clock-enable pulses ("ticks") in one fast reference clock domain. Each selector produces two outputs: a clock-enable pulse for logic that runs off the reference clock, and a square-wave clock level for consumers that need a real waveform.

A single 32-bit control register holds all six selectors' settings. It is written and read through a plain write-strobe / read-data port. Each 5-bit field has two parts: a source code, where zero means "off", and a 2-bit index into a post-divide table. The table has four entries and one of them is repeated. A build-time parameter picks between the default table and the extended table. The extended table swaps the repeated entry for a divide-by-3.

To avoid runt pulses, a selector that is running takes a new setting only when its divided output completes a full period. A selector that is off takes a new setting on the next cycle.

Top module: `cksel_bank`

## Requirements
- R1: The control register holds six 5-bit fields, with field i in bits [5i+4:5i]. A write takes effect on the clock edge where the write strobe is sampled. Bits 31:30 always read back as zero.
- R2: Field bits [4:2] are the source code. Code 0 turns the selector off. Code 1 selects src_tick[0], the auxiliary clock. Codes 2 to 7 select src_tick[code-1], frequency generators 0 to 5.
- R3: Field bits [1:0] index the divide table. With EXT_DIV=0 the ratios for indices 0, 1, 2, 3 are 1, 4, 1, 2.
- R4: With EXT_DIV=1 the ratios for indices 0, 1, 2, 3 are 1, 4, 3, 2.
- R5: While a selector is off, its out_en and out_clk are low and its phase is cleared. An off selector loads its field on the next edge, and counting of source ticks starts on the edge after that.
- R6: With ratio N, out_en is high for exactly one cycle, directly after every Nth selected tick counted since the selector was started.
- R7: For ratios 2 and 4, after the k-th selected tick since start, out_clk is high exactly when (k mod N) < N/2. out_clk changes only in the cycle after a selected tick.
- R8: For ratio 3, after the k-th selected tick, out_clk is high exactly when k mod 3 = 0. It is therefore high for one source period and low for two.
- R9: For ratio 1, out_en and out_clk both equal the selected tick delayed by one register stage.
- R10: While a selector is running, a changed field takes effect only on the edge where its out_en rises. Until then, its source and ratio stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 32 | Control register write value |
| rd_data | output | 32 | Control register contents |
| src_tick | input | 7 | Source enables: bit 0 auxiliary, bits 1 to 6 frequency generators 0 to 5 |
| out_en | output | 6 | Per-selector divided clock-enable pulse |
| out_clk | output | 6 | Per-selector divided square-wave clock |

## Verification
The assertions assume that every source enable is already synchronous to the reference clock. They also assume the control register changes only through the write port, so a field may change at any cycle, including in the middle of an output period. Source enables may arrive in every cycle, sparsely, or never. The stimulus covers all three cases: an auxiliary enable held high, generators ticking at different random densities, and a generator held silent so that a pending field change is left waiting on it. Field writes land at arbitrary points in a period, and two instances, one per table variant, receive the same stimulus.

// File: rtl/cksel_pkg.sv
// Package: shared field layout and divide-table decode for the selector bank.
// Assumes 3-bit source codes and 2-bit divide indices per field.
package cksel_pkg;

    localparam int SRC_W   = 3;
    localparam int IDX_W   = 2;
    localparam int FIELD_W = SRC_W + IDX_W;
    localparam int RATIO_W = 3;
    localparam int CNT_W   = 2;

    // One selector field: source code in the upper bits, table index below.
    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [IDX_W-1:0] idx;
    } sel_cfg_t;

    // Post-divide ratio for a table index; ext picks the divide-by-3 variant.
    function automatic logic [RATIO_W-1:0] ratio_of(input logic [IDX_W-1:0] idx,
                                                    input bit ext);
        logic [RATIO_W-1:0] r;
        case (idx)
            2'd0:    r = 3'd1;
            2'd1:    r = 3'd4;
            2'd2:    r = ext ? 3'd3 : 3'd1;
            default: r = 3'd2;
        endcase
        return r;
    endfunction

    // Number of phases per period during which the square wave is high.
    function automatic logic [RATIO_W-1:0] high_span(input logic [RATIO_W-1:0] r);
        return (r == 3'd3) ? 3'd1 : (r >> 1);
    endfunction

endpackage

// File: rtl/cksel_ctrl_reg.sv
// Control register: holds all selector fields and reads them back.
// Assumes NUM_SEL*FIELD_W <= REG_W; bits above the fields are stored as zero.
module cksel_ctrl_reg
    import cksel_pkg::*;
#(
    parameter int NUM_SEL = 6,
    parameter int REG_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] rd_data
);

    localparam int               USED_W = NUM_SEL * FIELD_W;
    localparam logic [REG_W-1:0] MASK   = ~({REG_W{1'b1}} << USED_W);

    // Register update: masked write, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= wr_data & MASK;
    end

    // Read port: the stored contents.
    assign rd_data = ctrl_q;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_q == ($past(wr_data) & MASK)));  // R1

endmodule

// File: rtl/cksel_div_core.sv
// Post-divider: counts selected ticks, emits one enable per period and a
// square wave. Assumes idx changes only while run is low or on a wrap edge.
module cksel_div_core
    import cksel_pkg::*;
#(
    parameter bit EXT_DIV = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [IDX_W-1:0] idx,
    output logic             wrap,
    output logic             en_q,
    output logic             clk_q
);

    logic [RATIO_W-1:0] ratio;
    logic [RATIO_W-1:0] span;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cnt_nx;
    logic               last;

    // Decode ratio and next phase from the active index and phase.
    always_comb begin
        ratio  = ratio_of(idx, EXT_DIV);
        span   = high_span(ratio);
        last   = ({1'b0, cnt_q} == (ratio - 3'd1));
        cnt_nx = last ? '0 : (cnt_q + CNT_W'(1));
        wrap   = run & tick & last;
    end

    // Phase counter and output registers; cleared whenever not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
            clk_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= cnt_nx;
            en_q  <= last;
            clk_q <= (ratio == 3'd1) ? 1'b1 : ({1'b0, cnt_nx} < span);
        end else begin
            en_q <= 1'b0;
            if (ratio == 3'd1)
                clk_q <= 1'b0;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt_q} < ratio));  // R6
    AST_DIV1_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && ratio == 3'd1) |=> (en_q && clk_q));  // R9
    AST_THIRD_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && clk_q && ratio == 3'd3) |=> !clk_q);  // R8
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!en_q && !clk_q));  // R5

endmodule

// File: rtl/cksel_selector.sv
// One consumer selector: keeps the active setting, routes the chosen source
// tick to its divider and takes a new field only at a period boundary.
// Assumes all source ticks are synchronous to clk.
module cksel_selector
    import cksel_pkg::*;
#(
    parameter int NUM_SRC = 7,
    parameter bit EXT_DIV = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick,
    input  sel_cfg_t           cfg,
    output logic               out_en,
    output logic               out_clk
);

    sel_cfg_t act_q;
    logic     run;
    logic     sel_tick;
    logic     wrap;
    logic     load;

    // Source routing: code c (c >= 1) picks tick c-1, code 0 picks nothing.
    always_comb begin
        run      = (act_q.src != '0);
        sel_tick = 1'b0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (run && (int'(act_q.src) == k + 1))
                sel_tick = src_tick[k];
        end
        load = !run || wrap;
    end

    // Active setting: follows the field when off, else only on a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= '0;
        else if (load)
            act_q <= cfg;
    end

    cksel_div_core #(
        .EXT_DIV (EXT_DIV)
    ) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (sel_tick),
        .idx   (act_q.idx),
        .wrap  (wrap),
        .en_q  (out_en),
        .clk_q (out_clk)
    );

    AST_SWITCH_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((act_q != $past(act_q)) && ($past(act_q.src) != '0)) |-> out_en);  // R10
    AST_EN_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> ($past(run) && $past(sel_tick)));  // R2

endmodule

// File: rtl/cksel_bank.sv
// Selector bank top: one control register feeding NUM_SEL selectors that
// share the same set of source ticks. Assumes NUM_SEL*5 <= REG_W.
module cksel_bank
    import cksel_pkg::*;
#(
    parameter int NUM_SEL = 6,
    parameter int NUM_GEN = 6,
    parameter int REG_W   = 32,
    parameter bit EXT_DIV = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    input  logic [NUM_GEN:0]   src_tick,
    output logic [NUM_SEL-1:0] out_en,
    output logic [NUM_SEL-1:0] out_clk
);

    localparam int NUM_SRC = NUM_GEN + 1;

    logic [REG_W-1:0] ctrl_q;

    cksel_ctrl_reg #(
        .NUM_SEL (NUM_SEL),
        .REG_W   (REG_W)
    ) reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .rd_data (rd_data)
    );

    // One selector per field slice.
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        sel_cfg_t fld;
        assign fld = sel_cfg_t'(ctrl_q[i*FIELD_W +: FIELD_W]);

        cksel_selector #(
            .NUM_SRC (NUM_SRC),
            .EXT_DIV (EXT_DIV)
        ) sel_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_tick (src_tick),
            .cfg      (fld),
            .out_en   (out_en[i]),
            .out_clk  (out_clk[i])
        );
    end

endmodule

// File: tb/cksel_bank_tb_top.sv
// Bench: behavioural per-cycle model of both table variants, compared on
// every falling edge, plus directed counting checks.
module cksel_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [6:0]  src_tick = '0;
    logic [31:0] rd_i, rd_x;
    logic [5:0]  en_i, ck_i, en_x, ck_x;

    int    checks = 0;
    int    errors = 0;
    int    tick_mode = 0;
    bit    cmp_on = 1'b0;
    string cur_req = "R5";

    always #5 clk = ~clk;

    cksel_bank #(.EXT_DIV(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_i), .src_tick(src_tick), .out_en(en_i), .out_clk(ck_i));

    cksel_bank #(.EXT_DIV(1'b1)) dut_x (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_x), .src_tick(src_tick), .out_en(en_x), .out_clk(ck_x));

    // Reference model state: [variant][selector]
    int          m_src [2][6];
    int          m_idx [2][6];
    int          m_cnt [2][6];
    bit          m_en  [2][6];
    bit          m_ck  [2][6];
    logic [31:0] m_ctrl;

    function automatic int m_ratio(int idx, int ext);
        case (idx)
            0: return 1;
            1: return 4;
            2: return ext ? 3 : 1;
            default: return 2;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0;
            for (int d = 0; d < 2; d++)
                for (int s = 0; s < 6; s++) begin
                    m_src[d][s] = 0; m_idx[d][s] = 0; m_cnt[d][s] = 0;
                    m_en[d][s] = 0;  m_ck[d][s] = 0;
                end
        end else begin
            for (int d = 0; d < 2; d++)
                for (int s = 0; s < 6; s++) begin
                    int fld, n, nc;
                    bit t;
                    fld = int'((m_ctrl >> (5 * s)) & 32'd31);
                    if (m_src[d][s] == 0) begin
                        m_en[d][s] = 0; m_ck[d][s] = 0; m_cnt[d][s] = 0;
                        m_src[d][s] = fld >> 2; m_idx[d][s] = fld & 3;
                    end else begin
                        n = m_ratio(m_idx[d][s], d);
                        t = src_tick[m_src[d][s] - 1];
                        if (t) begin
                            nc = (m_cnt[d][s] == n - 1) ? 0 : m_cnt[d][s] + 1;
                            m_en[d][s] = (nc == 0);
                            m_ck[d][s] = (n == 1) ? 1'b1 : (nc < ((n == 3) ? 1 : n / 2));
                            m_cnt[d][s] = nc;
                            if (nc == 0) begin
                                m_src[d][s] = fld >> 2; m_idx[d][s] = fld & 3;
                            end
                        end else begin
                            m_en[d][s] = 0;
                            if (n == 1) m_ck[d][s] = 0;
                        end
                    end
                end
            if (wr_en) m_ctrl = wr_data & 32'h3FFF_FFFF;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            for (int s = 0; s < 6; s++) begin
                chk(en_i[s] == m_en[0][s], cur_req, $sformatf("base out_en[%0d]", s), en_i[s], m_en[0][s]);
                chk(ck_i[s] == m_ck[0][s], cur_req, $sformatf("base out_clk[%0d]", s), ck_i[s], m_ck[0][s]);
                chk(en_x[s] == m_en[1][s], cur_req, $sformatf("ext out_en[%0d]", s), en_x[s], m_en[1][s]);
                chk(ck_x[s] == m_ck[1][s], cur_req, $sformatf("ext out_clk[%0d]", s), ck_x[s], m_ck[1][s]);
            end
            chk(rd_i == m_ctrl, "R1", "rd_data", int'(rd_i), int'(m_ctrl));
        end
    end

    task automatic new_ticks();
        if (tick_mode == 1) begin
            src_tick[0] = ($urandom % 2) == 0;
            for (int g = 1; g < 7; g++) src_tick[g] = ($urandom % (g + 1)) == 0;
        end
    endtask

    task automatic step(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            new_ticks();
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        new_ticks();
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        new_ticks();
        wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int c_en0, c_ck0, c_en1, c_ck1, x_ck0, x_en1;
        repeat (3) @(negedge clk);
        // Reset state
        chk(en_i == 0 && en_x == 0, "R5", "out_en in reset", int'(en_i), 0);
        chk(ck_i == 0 && ck_x == 0, "R5", "out_clk in reset", int'(ck_i), 0);
        chk(rd_i == 0, "R1", "rd_data in reset", int'(rd_i), 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // Directed: aux ticking every cycle; sel0 idx2, sel1 idx1, both on aux
        cur_req = "R3/R4/R6/R7/R8/R9";
        src_tick = 7'b000_0001;
        wr(32'h0000_00A6);
        @(posedge clk);
        c_en0 = 0; c_ck0 = 0; c_en1 = 0; c_ck1 = 0; x_ck0 = 0; x_en1 = 0;
        for (int c = 0; c < 36; c++) begin
            @(posedge clk); @(negedge clk);
            c_en0 += en_i[0]; c_ck0 += ck_i[0];
            c_en1 += en_i[1]; c_ck1 += ck_i[1];
            x_ck0 += ck_x[0]; x_en1 += en_x[1];
        end
        chk(c_en0 == 36, "R3", "base idx2 divides by 1, out_en count", c_en0, 36);
        chk(c_ck0 == 36, "R9", "ratio 1 out_clk count", c_ck0, 36);
        chk(c_en1 == 9,  "R6", "ratio 4 out_en count", c_en1, 9);
        chk(c_ck1 == 18, "R7", "ratio 4 out_clk high count", c_ck1, 18);
        chk(x_ck0 == 12, "R8", "ratio 3 out_clk high count", x_ck0, 12);
        chk(x_en1 == 9,  "R4", "ext idx1 ratio 4 out_en count", x_en1, 9);

        // Disable all
        cur_req = "R5";
        wr(32'h0);
        step(8);
        chk(en_i == 0 && en_x == 0, "R5", "out_en after disable", int'(en_i), 0);
        chk(ck_i == 0 && ck_x == 0, "R5", "out_clk after disable", int'(ck_i), 0);

        // Deferred change: sel2 on silent gen0, then retarget to aux
        cur_req = "R10";
        wr(32'h0000_2400);
        step(3);
        wr(32'h0000_1000);
        step(10);
        chk(en_i[2] == 0 && ck_i[2] == 0, "R10", "change held until boundary",
            int'({en_i[2], ck_i[2]}), 0);
        src_tick = 7'b000_0011;
        step(4);
        src_tick = 7'b000_0001;
        step(4);
        chk(en_i[2] == 1, "R2", "retargeted to aux after gen0 boundary", en_i[2], 1);

        // Unused bits read zero
        cur_req = "R1";
        wr(32'hFFFF_FFFF);
        chk(rd_i == 32'h3FFF_FFFF, "R1", "rd_data upper bits", int'(rd_i), 32'h3FFF_FFFF);

        // Random traffic with random reprogramming
        cur_req = "R2/R3/R4/R6/R7/R8/R10";
        tick_mode = 1;
        step(200);
        for (int k = 0; k < 8; k++) begin
            wr($urandom);
            step(150);
        end

        summary();
        $finish;
    end

endmodule